// File: doc/BRIEF.md
# Triggered Circular Trace Buffer

The block stores trace frames in a circular on-chip memory. A host enables capture through a small register port. While capture is running, every cycle that presents a valid frame passes that frame through a one-stage input register and then writes it at the write pointer. The pointer advances modulo the depth, and a sticky flag records that the memory has wrapped.

A trigger input marks the event of interest. From the cycle after the trigger, each accepted frame counts a host-loaded post-trigger counter down by one. When the counter is exhausted, acquisition completes and the memory is frozen, while the enable bit stays set. Afterwards the host reads the status and write pointer. If the wrap flag is set, it loads the read pointer with the write pointer. It then streams the frames oldest-first through an auto-incrementing data register.

Top module: `trace_capture_buf`

## Requirements
- R1: The register map uses word addresses 0 to 8. The registers are: 0 identification (reads ID_VALUE, default 32'h7A5E_0001), 1 depth (reads DEPTH, default 16), 2 word width (reads WORD_W, default 32), 3 status, 4 data, 5 read pointer, 6 write pointer, 7 post-trigger counter, 8 control. Unused addresses read 0. After reset, status reads 8 and the pointers, the counter and control read 0.
- R2: Writes to addresses 0 to 3 have no effect on any value read back.
- R3: Control bit 0 enables capture. While it is 1 and acquisition is not complete, each cycle with frame_valid high accepts frame_data. Each accepted frame is stored at the write pointer, and the write pointer then advances by one modulo DEPTH. A frame presented while bit 0 is 0 is dropped.
- R4: Status bit 0 (wrapped) is sticky. It sets when a frame is stored at location DEPTH-1.
- R5: Status bit 1 (triggered) sets when trig_in is high during capture. Each frame accepted in a later cycle decrements the counter. When the counter is zero after a trigger, status bit 2 (complete) sets and no further frame is accepted or stored. Control bit 0 stays 1. A counter of 0 at trigger time stores no post-trigger frame.
- R6: Status bit 3 (drained) is 0 while an accepted frame waits in the input register, and 1 otherwise.
- R7: A read of the data register returns the word at the read pointer and advances the read pointer modulo DEPTH. The read pointer is host-writable.
- R8: The write pointer and the counter are host-writable. A write of the write pointer takes priority over its own advance.
- R9: Writing control bit 0 from 0 to 1 clears status bits 0 to 2. Writing 0 stops capture and leaves the status unchanged.
- R10: Control bit 1 (demultiplexed port mode) is stored and read back. It has no effect on capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_valid | input | 1 | A trace frame is presented this cycle |
| frame_data | input | WORD_W | Trace frame contents |
| trig_in | input | 1 | Trigger event |
| reg_addr | input | 4 | Register word address |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe (advances the read pointer on the data register) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |

## Verification
The hardest state to reach from the ports is the exact end of acquisition. The trigger cycle, the countdown and the completion cycle must line up frame by frame, and the input register must drain in the same edge that freezes the memory. The bench presents frames back to back in consecutive cycles, with the trigger on a chosen frame, and keeps sending frames past the expected end. It then checks the write pointer and the status, so one frame too many or too few shows up as a pointer mismatch. The wrapped read-back is reached by sending more frames than the depth and reading the whole memory starting from the write pointer.

// File: rtl/tcb_pkg.sv
package tcb_pkg;
    localparam int REG_W  = 32;
    localparam int ADDR_W = 4;

    typedef enum logic [ADDR_W-1:0] {
        A_IDENT = 4'd0,
        A_DEPTH = 4'd1,
        A_WIDTH = 4'd2,
        A_STAT  = 4'd3,
        A_DATA  = 4'd4,
        A_RPTR  = 4'd5,
        A_WPTR  = 4'd6,
        A_TCNT  = 4'd7,
        A_CTRL  = 4'd8
    } tcb_addr_e;
endpackage

// File: rtl/tcb_ram.sv
module tcb_ram #(
    parameter int DEPTH  = 16,
    parameter int WORD_W = 32,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [PTR_W-1:0]  waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [PTR_W-1:0]  raddr,
    output logic [WORD_W-1:0] rdata
);
    logic [WORD_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/tcb_acq.sv
module tcb_acq #(
    parameter int DEPTH  = 16,
    parameter int WORD_W = 32,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              start,
    input  logic              frame_valid,
    input  logic [WORD_W-1:0] frame_data,
    input  logic              trig_in,
    input  logic              wptr_we,
    input  logic [PTR_W-1:0]  wptr_wdata,
    input  logic              cnt_we,
    input  logic [31:0]       cnt_wdata,
    output logic              ram_we,
    output logic [PTR_W-1:0]  ram_waddr,
    output logic [WORD_W-1:0] ram_wdata,
    output logic [PTR_W-1:0]  wptr,
    output logic [31:0]       cnt,
    output logic              full,
    output logic              trig,
    output logic              acq,
    output logic              drained
);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    typedef struct packed {
        logic              stg_v;
        logic [WORD_W-1:0] stg_d;
        logic [PTR_W-1:0]  wptr;
        logic [31:0]       cnt;
        logic              full;
        logic              trig;
        logic              acq;
    } acq_st_t;

    acq_st_t s_d, s_q;
    logic    capture;
    logic    take;

    always_comb begin
        s_d     = s_q;
        capture = en && !s_q.acq && !(s_q.trig && (s_q.cnt == 32'd0));
        take    = capture && frame_valid;

        s_d.stg_v = take;
        if (take) s_d.stg_d = frame_data;

        if (s_q.stg_v) begin
            s_d.wptr = (s_q.wptr == LAST) ? '0 : s_q.wptr + 1'b1;
            if (s_q.wptr == LAST) s_d.full = 1'b1;
        end

        if (capture && trig_in) s_d.trig = 1'b1;
        if (take && s_q.trig) s_d.cnt = s_q.cnt - 32'd1;
        if (en && s_q.trig && !s_q.acq && (s_q.cnt == 32'd0)) s_d.acq = 1'b1;

        if (wptr_we) s_d.wptr = wptr_wdata;
        if (cnt_we)  s_d.cnt  = cnt_wdata;

        if (start) begin
            s_d.full = 1'b0;
            s_d.trig = 1'b0;
            s_d.acq  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ram_we    = s_q.stg_v;
    assign ram_waddr = s_q.wptr;
    assign ram_wdata = s_q.stg_d;
    assign wptr      = s_q.wptr;
    assign cnt       = s_q.cnt;
    assign full      = s_q.full;
    assign trig      = s_q.trig;
    assign acq       = s_q.acq;
    assign drained   = !s_q.stg_v;
endmodule

// File: rtl/trace_capture_buf.sv
module trace_capture_buf
    import tcb_pkg::*;
#(
    parameter int          DEPTH    = 16,
    parameter int          WORD_W   = 32,
    parameter logic [31:0] ID_VALUE = 32'h7A5E_0001
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_valid,
    input  logic [WORD_W-1:0] frame_data,
    input  logic              trig_in,
    input  logic [3:0]        reg_addr,
    input  logic              reg_we,
    input  logic              reg_re,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    generate
        if (WORD_W > REG_W || WORD_W < 1) begin : g_bad_width
            initial $error("WORD_W must be 1..32");
        end
        if ((1 << PTR_W) != DEPTH) begin : g_bad_depth
            initial $error("DEPTH must be a power of two");
        end
    endgenerate

    typedef struct packed {
        logic [1:0]       ctrl;
        logic [PTR_W-1:0] rptr;
    } top_st_t;

    top_st_t t_d, t_q;

    logic              start_pulse;
    logic              ram_we;
    logic [PTR_W-1:0]  ram_waddr;
    logic [WORD_W-1:0] ram_wdata;
    logic [WORD_W-1:0] ram_rdata;
    logic [PTR_W-1:0]  wptr;
    logic [31:0]       cnt;
    logic              full, trig, acq, drained;
    logic              wr_ctrl, wr_rptr, wr_wptr, wr_tcnt, rd_data;

    always_comb begin
        wr_ctrl = reg_we && (reg_addr == A_CTRL);
        wr_rptr = reg_we && (reg_addr == A_RPTR);
        wr_wptr = reg_we && (reg_addr == A_WPTR);
        wr_tcnt = reg_we && (reg_addr == A_TCNT);
        rd_data = reg_re && (reg_addr == A_DATA);
        start_pulse = wr_ctrl && reg_wdata[0] && !t_q.ctrl[0];

        t_d = t_q;
        if (wr_ctrl) t_d.ctrl = reg_wdata[1:0];
        if (wr_rptr)      t_d.rptr = reg_wdata[PTR_W-1:0];
        else if (rd_data) t_d.rptr = (t_q.rptr == LAST) ? '0 : t_q.rptr + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    tcb_acq #(.DEPTH(DEPTH), .WORD_W(WORD_W)) acq_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (t_q.ctrl[0]),
        .start      (start_pulse),
        .frame_valid(frame_valid),
        .frame_data (frame_data),
        .trig_in    (trig_in),
        .wptr_we    (wr_wptr),
        .wptr_wdata (reg_wdata[PTR_W-1:0]),
        .cnt_we     (wr_tcnt),
        .cnt_wdata  (reg_wdata),
        .ram_we     (ram_we),
        .ram_waddr  (ram_waddr),
        .ram_wdata  (ram_wdata),
        .wptr       (wptr),
        .cnt        (cnt),
        .full       (full),
        .trig       (trig),
        .acq        (acq),
        .drained    (drained)
    );

    tcb_ram #(.DEPTH(DEPTH), .WORD_W(WORD_W)) ram_i (
        .clk  (clk),
        .we   (ram_we),
        .waddr(ram_waddr),
        .wdata(ram_wdata),
        .raddr(t_q.rptr),
        .rdata(ram_rdata)
    );

    always_comb begin
        case (reg_addr)
            A_IDENT: reg_rdata = ID_VALUE;
            A_DEPTH: reg_rdata = REG_W'(DEPTH);
            A_WIDTH: reg_rdata = REG_W'(WORD_W);
            A_STAT:  reg_rdata = {28'd0, drained, acq, trig, full};
            A_DATA:  reg_rdata = REG_W'(ram_rdata);
            A_RPTR:  reg_rdata = REG_W'(t_q.rptr);
            A_WPTR:  reg_rdata = REG_W'(wptr);
            A_TCNT:  reg_rdata = cnt;
            A_CTRL:  reg_rdata = REG_W'(t_q.ctrl);
            default: reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/tcb_checks.sv
module tcb_checks #(
    parameter int DEPTH = 16,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             en,
    input logic             full,
    input logic             trig,
    input logic             acq,
    input logic             drained,
    input logic             frame_valid,
    input logic             wr_wptr,
    input logic             wr_rptr,
    input logic             rd_data,
    input logic [PTR_W-1:0] wptr,
    input logic [PTR_W-1:0] rptr
);
    // R4: wrap flag only clears on a capture start
    a_r4_full_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        full && !start |=> full);

    // R9: a capture start clears the three sticky status bits
    a_r9_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !full && !trig && !acq);

    // R5: memory is frozen once acquisition has completed
    a_r5_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        acq && !start && !wr_wptr |=> $stable(wptr));

    // R5: completion leaves the enable bit set
    a_r5_enable_kept: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(acq) |-> en);

    // R6: an accepted frame shows as not drained in the next cycle
    a_r6_not_drained: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid && en && !acq && !(trig && !drained && 1'b0) && !trig |=> !drained);

    // R7: a data read advances the read pointer modulo the depth
    a_r7_rptr_adv: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data && !wr_rptr |=>
        (rptr == (($past(rptr) == PTR_W'(DEPTH - 1)) ? '0 : $past(rptr) + 1'b1)));
endmodule

bind trace_capture_buf tcb_checks #(.DEPTH(DEPTH)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start_pulse),
    .en         (t_q.ctrl[0]),
    .full       (full),
    .trig       (trig),
    .acq        (acq),
    .drained    (drained),
    .frame_valid(frame_valid),
    .wr_wptr    (wr_wptr),
    .wr_rptr    (wr_rptr),
    .rd_data    (rd_data),
    .wptr       (wptr),
    .rptr       (t_q.rptr)
);

// File: tb/trace_capture_buf_tb_top.sv
`timescale 1ns/1ps
module trace_capture_buf_tb_top;
    localparam int DEPTH  = 16;
    localparam int WORD_W = 32;
    localparam logic [3:0] A_IDENT = 4'd0, A_DEPTH = 4'd1, A_WIDTH = 4'd2, A_STAT = 4'd3,
                           A_DATA = 4'd4, A_RPTR = 4'd5, A_WPTR = 4'd6, A_TCNT = 4'd7,
                           A_CTRL = 4'd8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              frame_valid = 1'b0;
    logic [WORD_W-1:0] frame_data = '0;
    logic              trig_in = 1'b0;
    logic [3:0]        reg_addr = '0;
    logic              reg_we = 1'b0;
    logic              reg_re = 1'b0;
    logic [31:0]       reg_wdata = '0;
    logic [31:0]       reg_rdata;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    trace_capture_buf #(.DEPTH(DEPTH), .WORD_W(WORD_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .frame_valid(frame_valid), .frame_data(frame_data),
        .trig_in(trig_in), .reg_addr(reg_addr), .reg_we(reg_we), .reg_re(reg_re),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(posedge clk); #1;
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a; reg_re = 1'b1;
        #1 v = reg_rdata;
        @(posedge clk); #1;
        reg_re = 1'b0;
    endtask

    task automatic send(input logic [31:0] d, input logic t);
        @(negedge clk);
        frame_valid = 1'b1; frame_data = d; trig_in = t;
        @(posedge clk); #1;
        frame_valid = 1'b0; trig_in = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic restart(input logic [31:0] count);
        wr(A_CTRL, 32'd0);
        wr(A_WPTR, 32'd0);
        wr(A_TCNT, count);
        wr(A_CTRL, 32'd1);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(A_IDENT, v); check("R1 ident", v, 32'h7A5E_0001);
        rd(A_DEPTH, v); check("R1 depth", v, DEPTH);
        rd(A_WIDTH, v); check("R1 width", v, WORD_W);
        rd(A_STAT, v);  check("R1 status", v, 32'd8);
        rd(A_RPTR, v);  check("R1 rptr", v, 0);
        rd(A_WPTR, v);  check("R1 wptr", v, 0);
        rd(A_TCNT, v);  check("R1 tcnt", v, 0);
        rd(A_CTRL, v);  check("R1 ctrl", v, 0);
        rd(4'd12, v);   check("R1 unused", v, 0);
    endtask

    task automatic t_readonly();
        logic [31:0] v;
        wr(A_IDENT, 32'hFFFF_FFFF); wr(A_DEPTH, 32'hFFFF_FFFF);
        wr(A_WIDTH, 32'hFFFF_FFFF); wr(A_STAT, 32'hFFFF_FFFF);
        rd(A_IDENT, v); check("R2 ident", v, 32'h7A5E_0001);
        rd(A_DEPTH, v); check("R2 depth", v, DEPTH);
        rd(A_WIDTH, v); check("R2 width", v, WORD_W);
        rd(A_STAT, v);  check("R2 status", v, 32'd8);
    endtask

    task automatic t_basic();
        logic [31:0] v;
        restart(32'd100);
        for (int i = 0; i < 5; i++) send(32'hA000 + i, 1'b0);
        idle(2);
        rd(A_WPTR, v); check("R3 wptr after 5", v, 5);
        rd(A_STAT, v); check("R4 no wrap", v, 32'd8);
        // drained flag around one frame (R6)
        @(negedge clk); frame_valid = 1'b1; frame_data = 32'hA005;
        @(posedge clk); #1; frame_valid = 1'b0; reg_addr = A_STAT;
        #1 check("R6 busy", {31'd0, reg_rdata[3]}, 0);
        @(posedge clk); #1;
        check("R6 drained", {31'd0, reg_rdata[3]}, 1);
        wr(A_CTRL, 32'd0);
        send(32'hDEAD, 1'b0);
        idle(2);
        rd(A_WPTR, v); check("R3 dropped when off", v, 6);
        wr(A_RPTR, 32'd0);
        for (int i = 0; i < 6; i++) begin
            rd(A_DATA, v); check("R7 data", v, 32'hA000 + i);
        end
        rd(A_RPTR, v); check("R7 rptr advanced", v, 6);
    endtask

    task automatic t_wrap();
        logic [31:0] v;
        restart(32'd1000);
        for (int i = 0; i < 20; i++) send(32'hB00 + i, 1'b0);
        idle(2);
        rd(A_WPTR, v); check("R3 wptr wraps", v, 4);
        rd(A_STAT, v); check("R4 wrapped", v, 32'd9);
        wr(A_CTRL, 32'd0);
        wr(A_RPTR, 32'd4);
        for (int k = 0; k < 16; k++) begin
            rd(A_DATA, v); check("R7 oldest first", v, 32'hB00 + 4 + k);
        end
        rd(A_RPTR, v); check("R7 rptr wraps", v, 4);
    endtask

    task automatic t_trigger();
        logic [31:0] v;
        restart(32'd3);
        rd(A_STAT, v); check("R9 start clears", v, 32'd8);
        send(32'hC0, 1'b0); send(32'hC1, 1'b0); send(32'hC2, 1'b1);
        for (int i = 3; i < 9; i++) send(32'hC0 + i, 1'b0);
        idle(2);
        rd(A_WPTR, v); check("R5 stored frames", v, 6);
        rd(A_STAT, v); check("R5 status complete", v, 32'hE);
        rd(A_TCNT, v); check("R5 count zero", v, 0);
        rd(A_CTRL, v); check("R5 enable kept", v, 1);
        wr(A_RPTR, 32'd5);
        rd(A_DATA, v); check("R5 last stored", v, 32'hC5);
        wr(A_CTRL, 32'd0);
        rd(A_STAT, v); check("R9 stop keeps status", v, 32'hE);
        wr(A_CTRL, 32'd1);
        rd(A_STAT, v); check("R9 restart clears", v, 32'd8);
    endtask

    task automatic t_zero_count();
        logic [31:0] v;
        restart(32'd0);
        send(32'hD0, 1'b1);
        for (int i = 1; i < 4; i++) send(32'hD0 + i, 1'b0);
        idle(2);
        rd(A_WPTR, v); check("R5 zero count", v, 1);
        rd(A_STAT, v); check("R5 zero count status", v, 32'hE);
    endtask

    task automatic t_ptr_write();
        logic [31:0] v;
        restart(32'd50);
        wr(A_WPTR, 32'd9);
        send(32'hE9, 1'b0);
        idle(2);
        rd(A_WPTR, v); check("R8 wptr written", v, 10);
        wr(A_TCNT, 32'h1234_5678);
        rd(A_TCNT, v); check("R8 tcnt written", v, 32'h1234_5678);
        wr(A_CTRL, 32'd0);
        wr(A_RPTR, 32'd9);
        rd(A_DATA, v); check("R8 frame at new wptr", v, 32'hE9);
    endtask

    task automatic t_demux();
        logic [31:0] v;
        wr(A_CTRL, 32'd0);
        wr(A_WPTR, 32'd0);
        wr(A_TCNT, 32'd50);
        wr(A_CTRL, 32'd3);
        rd(A_CTRL, v); check("R10 ctrl readback", v, 3);
        send(32'hF0, 1'b0); send(32'hF1, 1'b0);
        idle(2);
        rd(A_WPTR, v); check("R10 capture unchanged", v, 2);
        wr(A_CTRL, 32'd0);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_readonly();
        t_basic();
        t_wrap();
        t_trigger();
        t_zero_count();
        t_ptr_write();
        t_demux();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule